// File: doc/BRIEF.md
# SPI Flash Controller Register Block

This block is the register front end of a serial flash controller. It keeps a bank of 64 word-wide registers behind a simple word-addressed bus and drives one active-low chip-select line for each attached flash device. Software writes a device's control register to select or release that device. The serial shifter, command sequencing, the flash data windows and interrupts live elsewhere.

A build-time parameter chooses between two register maps. The multi-device map supports up to five devices, and their control registers sit at a 4-byte stride from byte offset 0x10. The single-device map supports one device, and its control register sits at byte offset 0x04. The requested device count is clamped to the chosen map's limit. In every control register, bit 2 is the "stop" flag, and its value drives that device's chip-select line directly. Bits [1:0] (the value 3 means command mode) and bits [23:16] (a command byte) are stored but do not drive any logic in this block.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset every register reads zero, except the control register of each configured device, which reads 0x0000_0004. Every `cs_n` line is 1.
- R2: A write at a byte address below 0x100 stores all 32 bits at index `addr[7:2]`. A read returns the stored word on `bus_rdata` one clock edge after the read is accepted.
- R3: Accesses at byte addresses 0x100 and above are ignored. Writes there change no register and no `cs_n` line, and reads there return 0.
- R4: In the multi-device map, device i (0 to 4) has its control register at byte 0x10 + 4*i, and `cs_n[i]` equals bit 2 of that register.
- R5: In the single-device map, device 0 has its control register at byte 0x04, and `cs_n[0]` equals bit 2 of that register.
- R6: A write to a control register lands on the edge that accepts it. The matching `cs_n` line changes on the following edge. Back-to-back writes to the same register take effect in order.
- R7: Writes to registers other than the configured devices' control registers never change `cs_n`.
- R8: The device count is the requested count clamped to the range 1 to 5 in the multi-device map and to exactly 1 in the single-device map. `cs_n` lines above the device count stay at 1 whatever is written.
- R9: Only bit 2 of a control register drives the chip-select line. The mode bits and the command byte are kept intact and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cs_n | output | 5 | Per-device chip select, active low |

## Verification
A corrupted register image shows up on `bus_rdata` one edge after that index is read. For a control register, it also shows on `cs_n` one edge after the next write to any control register. A chip-select line that holds a stale value, or one that moves without a control write, shows within two edges of the write, because the bench samples `cs_n` both before and after the update edge. A wrong index map or a wrong clamp sends a write to the wrong slot. That shows as the wrong `cs_n` bit moving, or as an unused line going low, on the edge after the write.

// File: rtl/spifc_pkg.sv
package spifc_pkg;

    localparam int REG_COUNT = 64;
    localparam int DATA_W    = 32;
    localparam int CS_MAX    = 5;
    localparam int STOP_BIT  = 2;
    localparam int IDX_W     = $clog2(REG_COUNT);

    typedef enum logic {
        MAP_MULTI  = 1'b0,
        MAP_SINGLE = 1'b1
    } map_e;

    function automatic int ctrl_index(map_e m);
        return (m == MAP_MULTI) ? 4 : 1;
    endfunction

    function automatic int dev_limit(map_e m);
        return (m == MAP_MULTI) ? CS_MAX : 1;
    endfunction

    function automatic int clamp_devs(map_e m, int req);
        int lim;
        lim = dev_limit(m);
        if (req < 1)   return 1;
        if (req > lim) return lim;
        return req;
    endfunction

endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
    import spifc_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int CTRL_BASE = 4,
    parameter int NDEV      = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              wr_en,
    output logic              rd_en,
    output logic              wr_ctrl,
    output logic [NDEV-1:0]   ctrl_hit
);

    always_comb begin
        idx      = addr[IDX_W+1:2];
        in_range = (addr >> (IDX_W + 2)) == '0;
        wr_en    = sel && we && in_range;
        rd_en    = sel && !we;
    end

    for (genvar i = 0; i < NDEV; i++) begin : g_hit
        assign ctrl_hit[i] = wr_en && (idx == IDX_W'(CTRL_BASE + i));
    end

    assign wr_ctrl = |ctrl_hit;

endmodule

// File: rtl/fcr_regfile.sv
module fcr_regfile
    import spifc_pkg::*;
#(
    parameter int CTRL_BASE = 4,
    parameter int NDEV      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              in_range,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NDEV-1:0]   stop
);

    typedef struct packed {
        logic [REG_COUNT-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]                rdata;
    } rf_t;

    rf_t st_d, st_q;

    function automatic rf_t rf_reset();
        rf_t r;
        r = '0;
        for (int i = 0; i < NDEV; i++) r.mem[CTRL_BASE + i][STOP_BIT] = 1'b1;
        return r;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.mem[idx] = wdata;
        if (rd_en) st_d.rdata = in_range ? st_q.mem[idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= rf_reset();
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    for (genvar i = 0; i < NDEV; i++) begin : g_stop
        assign stop[i] = st_q.mem[CTRL_BASE + i][STOP_BIT];
    end

endmodule

// File: rtl/fcr_csel.sv
module fcr_csel
    import spifc_pkg::*;
#(
    parameter int NDEV = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [NDEV-1:0]   stop,
    output logic [CS_MAX-1:0] cs_n
);

    typedef struct packed {
        logic              upd;
        logic [CS_MAX-1:0] cs;
    } cs_t;

    cs_t st_d, st_q;
    logic [CS_MAX-1:0] level;

    for (genvar i = 0; i < CS_MAX; i++) begin : g_lvl
        if (i < NDEV) begin : g_used
            assign level[i] = stop[i];
        end else begin : g_idle
            assign level[i] = 1'b1;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = wr_ctrl;
        if (st_q.upd) st_d.cs = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{upd: 1'b0, cs: '1};
        else        st_q <= st_d;
    end

    assign cs_n = st_q.cs;

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import spifc_pkg::*;
#(
    parameter map_e MAP     = MAP_MULTI,
    parameter int   DEV_REQ = 5,
    parameter int   ADDR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CS_MAX-1:0] cs_n
);

    localparam int NDEV      = clamp_devs(MAP, DEV_REQ);
    localparam int CTRL_BASE = ctrl_index(MAP);

    logic [IDX_W-1:0] idx;
    logic             in_range, wr_en, rd_en, wr_ctrl;
    logic [NDEV-1:0]  ctrl_hit;
    logic [NDEV-1:0]  stop;

    fcr_decode #(.ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE), .NDEV(NDEV)) u_dec (
        .sel(bus_sel), .we(bus_we), .addr(bus_addr),
        .idx(idx), .in_range(in_range), .wr_en(wr_en), .rd_en(rd_en),
        .wr_ctrl(wr_ctrl), .ctrl_hit(ctrl_hit)
    );

    fcr_regfile #(.CTRL_BASE(CTRL_BASE), .NDEV(NDEV)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .in_range(in_range), .idx(idx), .wdata(bus_wdata),
        .rdata(bus_rdata), .stop(stop)
    );

    fcr_csel #(.NDEV(NDEV)) u_cs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .stop(stop), .cs_n(cs_n)
    );

    // R3: reads beyond the register space return zero
    a_r3_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr >> (IDX_W + 2)) != '0) |=> bus_rdata == '0);

    // R7: a chip-select change needs a control write two edges earlier
    a_r7_cs_needs_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> $past(wr_ctrl, 2));

    for (genvar i = 0; i < CS_MAX; i++) begin : g_chk
        if (i < NDEV) begin : g_used
            // R4/R6: the written stop bit reaches cs_n one edge after the write lands
            a_r4_cs_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_hit[i] |-> ##2 (cs_n[i] == $past(bus_wdata[STOP_BIT], 2)));
        end else begin : g_idle
            // R8: lines beyond the device count stay high
            a_r8_unused_high: assert property (@(posedge clk) disable iff (!rst_n)
                cs_n[i] == 1'b1);
        end
    end

endmodule

// File: tb/test_flash_ctl_regs.sv
`timescale 1ns/1ps
module test_flash_ctl_regs;
    import spifc_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata_a, rdata_b;
    wire  [4:0]  cs_a, cs_b;

    always #2.5 clk = ~clk;

    flash_ctl_regs #(.MAP(MAP_MULTI), .DEV_REQ(5), .ADDR_W(10)) i_flash_ctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_a), .cs_n(cs_a));

    flash_ctl_regs #(.MAP(MAP_SINGLE), .DEV_REQ(3), .ADDR_W(10)) i_flash_ctl_regs_spi (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_b), .cs_n(cs_b));

    int          n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0] model [64];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) rd_seen <= sel_a & ~we;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("R2 scoreboard underflow", 32'd1, 32'd0);
            else check(tag_q.pop_front(), rdata_a, exp_q.pop_front());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic bus_wr(bit to_b, logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        sel_a = !to_b; sel_b = to_b; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        sel_a = 1'b0; sel_b = 1'b0; we = 1'b0;
        if (!to_b && a < 10'h100) model[a[7:2]] = d;
    endtask

    task automatic rd_a(logic [9:0] a, string tag);
        @(negedge clk);
        sel_a = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back((a < 10'h100) ? model[a[7:2]] : 32'd0);
        tag_q.push_back(tag);
        @(posedge clk); @(negedge clk);
        sel_a = 1'b0;
    endtask

    task automatic rd_b(logic [9:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        sel_b = 1'b1; we = 1'b0; addr = a;
        @(posedge clk); @(negedge clk);
        sel_b = 1'b0;
        check(tag, rdata_b, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model[i] = 32'd0;
        for (int i = 4; i < 9; i++) model[i] = 32'd4;
    endtask

    initial begin
        do_reset();
        check("R1 reset cs_n multi", {27'd0, cs_a}, 32'h1f);
        check("R1 reset cs_n single", {27'd0, cs_b}, 32'h1f);
        for (int i = 0; i < 64; i++) rd_a(10'(i * 4), "R1 reset image");

        bus_wr(0, 10'h000, 32'hFFFF_0001);
        check("R7 config write, cs_n", {27'd0, cs_a}, 32'h1f);
        tick();
        check("R7 config write, cs_n later", {27'd0, cs_a}, 32'h1f);

        bus_wr(0, 10'h050, 32'hA5A5_5A5A);
        bus_wr(0, 10'h0FC, 32'hDEAD_BEEF);
        rd_a(10'h050, "R2 readback idx20");
        rd_a(10'h0FC, "R2 readback idx63");
        rd_a(10'h000, "R2 readback config");

        bus_wr(0, 10'h018, 32'h00AB_0003);
        check("R6 cs_n before update edge", {27'd0, cs_a}, 32'h1f);
        tick();
        check("R4 dev2 selected", {27'd0, cs_a}, 32'h1b);
        rd_a(10'h018, "R9 mode and command kept");

        bus_wr(0, 10'h010, 32'h0); tick();
        check("R4 dev0 selected", {27'd0, cs_a}, 32'h1a);
        bus_wr(0, 10'h020, 32'h0); tick();
        check("R4 dev4 selected", {27'd0, cs_a}, 32'h0a);
        bus_wr(0, 10'h018, 32'h00FF_0007); tick();
        check("R9 stop bit alone releases dev2", {27'd0, cs_a}, 32'h0e);
        rd_a(10'h018, "R9 full word stored");

        bus_wr(0, 10'h100, 32'h1234_5678);
        bus_wr(0, 10'h110, 32'h0000_0004); tick();
        check("R3 out-of-range write leaves cs_n", {27'd0, cs_a}, 32'h0e);
        rd_a(10'h000, "R3 alias slot untouched");
        rd_a(10'h010, "R3 ctrl alias untouched");
        rd_a(10'h110, "R3 out-of-range read zero");
        rd_a(10'h3FC, "R3 top read zero");

        bus_wr(0, 10'h024, 32'h0000_0012); tick();
        check("R7 idx9 write leaves cs_n", {27'd0, cs_a}, 32'h0e);
        rd_a(10'h024, "R2 idx9 stored");

        bus_wr(0, 10'h014, 32'h0);
        bus_wr(0, 10'h014, 32'h4);
        check("R6 back-to-back first value", {27'd0, cs_a}, 32'h0c);
        tick();
        check("R6 back-to-back second value", {27'd0, cs_a}, 32'h0e);

        do_reset();
        check("R1 cs_n after second reset", {27'd0, cs_a}, 32'h1f);
        rd_a(10'h018, "R1 ctrl reset value");
        rd_a(10'h000, "R1 config cleared");
        rd_a(10'h050, "R1 data cleared");

        rd_b(10'h004, 32'h4, "R5 single ctrl reset value");
        rd_b(10'h010, 32'h0, "R8 no ctrl at 0x10 when clamped");
        bus_wr(1, 10'h004, 32'h0); tick();
        check("R5 single dev0 selected", {27'd0, cs_b}, 32'h1e);
        bus_wr(1, 10'h008, 32'h4);
        bus_wr(1, 10'h010, 32'h0);
        bus_wr(1, 10'h010, 32'h4); tick();
        check("R8 clamped slots inert", {27'd0, cs_b}, 32'h1e);
        check("R7 multi untouched by single writes", {27'd0, cs_a}, 32'h1f);
        bus_wr(1, 10'h004, 32'h4); tick();
        check("R5 single dev0 released", {27'd0, cs_b}, 32'h1f);

        repeat (3) tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule